// File: doc/BRIEF.md
# Slow-Control Request Engine

This block turns one slow-control request into register accesses and one reply. The request reaches it as a stream of 32-bit words. That stream is the payload of a datagram, with the network and transport headers already removed, and it ends with a last-word flag. The block stores the whole request before acting on it. If the request is well formed, the block runs each register access it describes on a simple internal bus, one access at a time. It then streams back a reply that starts with a copy of the header and holds one status word and one value word for each access. If the request is rejected, the block touches no register and sends a two-word error reply.

A request carries, in order: an identifier, a subaddress, a command word, a command argument, and zero or more payload words. The upper half of the command word selects the operation (0xAAAA write, 0xBBBB read). The lower half selects the form (0xFFFF for address/value pairs or an address list, 0xBBBB for a burst from a start address). Three per-frame flags from the receive side travel with the words on `s_flags`, and the block ORs them over the frame: bit 0 marks a forbidden source port, bit 1 marks a length that is not a whole number of words, and bit 2 marks a bad checksum.

Back-pressure rules. `s_ready` is high only while no request is held. It falls in the cycle after the last word is accepted and stays low until the reply's last word has been accepted. `m_valid` is never withdrawn before a handshake. `m_data` and `m_last` do not change while `m_valid` is high and `m_ready` is low.

Top module: `sc_request_engine`

## Requirements
- R1: A reply to an accepted request begins with four words: the identifier with bit 31 forced to 0, then the subaddress, the command word and the command argument, copied unchanged.
- R2: Command 0xAAAAFFFF takes its payload as alternating address and value words, writes each value to its address in order, and ignores the command argument.
- R3: Command 0xAAAABBBB writes payload word k to address (command argument + k).
- R4: Command 0xBBBBBBBB reads one register per payload word, from address (command argument + k). The payload words themselves are ignored.
- R5: Command 0xBBBBFFFF reads each payload word's address in turn.
- R6: Each access adds a status word and then a value word to the reply. The status is 0 when acknowledged. The value is the written value for a write and the bus read data for a read.
- R7: An access with no acknowledge within TIMEOUT cycles of raised request ends with status 1 and value equal to the written value (write) or 0 (read). An acknowledge in the final cycle of that window still counts as success.
- R8: A rejected request gives exactly two reply words: the identifier with bit 31 cleared, then the error word with `m_last`. No bus access takes place.
- R9: Frame error bits: 26 when identifier bit 31 is 0, 27 when fewer than 4 words arrive, 28 for `s_flags[1]`, 29 for overflow, 30 for `s_flags[0]`. Every bit that applies is set.
- R10: When no frame error bit is set, bit 19 marks an unknown command word and bit 18 marks an odd payload count on a pair write. Bit 16 reflects `s_flags[2]` in every case.
- R11: Handshakes obey the back-pressure rules above. `m_last` marks the final reply word. After reset, `s_ready` is 1 and `m_valid` and `bus_req` are 0.
- R12: Up to DEPTH payload words are accepted normally. Any more sets error bit 29.
- R13: A request with no payload words gives a header-only reply with `m_last` on the command argument word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Request word valid |
| s_ready | output | 1 | Engine can accept a request word |
| s_data | input | 32 | Request word |
| s_last | input | 1 | Final word of the request |
| s_flags | input | 3 | Receive-side problems, ORed over the frame |
| m_valid | output | 1 | Reply word valid |
| m_ready | input | 1 | Reply sink accepts word |
| m_data | output | 32 | Reply word |
| m_last | output | 1 | Final word of the reply |
| bus_req | output | 1 | Register access pending |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 32 | Register address |
| bus_wdata | output | 32 | Write value |
| bus_ack | input | 1 | Access acknowledged this cycle |
| bus_rdata | input | 32 | Read value, valid with bus_ack |

## Verification
Two things can fall in the same cycle: the bus acknowledge being captured, and the timeout counter reaching its limit. The bench's register model holds back its acknowledge for every address whose bits 15:8 are 0xCF, so that it arrives in exactly the last cycle of the window. Such accesses are judged by a zero status word and the true read or written value. Addresses whose bits 15:8 are 0xDE are never acknowledged, which exercises the expiry alone. Random back-pressure on `m_ready` runs alongside, and the bench checks that the reply is held while each access waits for its outcome.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int WORD_W = 32;

  // command word halves
  localparam logic [15:0] OP_WRITE    = 16'hAAAA;
  localparam logic [15:0] OP_READ     = 16'hBBBB;
  localparam logic [15:0] FORM_SINGLE = 16'hFFFF;
  localparam logic [15:0] FORM_BURST  = 16'hBBBB;

  // error reply bit positions
  localparam int EB_BADPORT  = 30;
  localparam int EB_OVERFLOW = 29;
  localparam int EB_PARTIAL  = 28;
  localparam int EB_SHORT    = 27;
  localparam int EB_IDMSB    = 26;
  localparam int EB_UNKNOWN  = 19;
  localparam int EB_BADFORM  = 18;
  localparam int EB_CSUM     = 16;

  // receive-side flag positions
  localparam int FL_PORT    = 0;
  localparam int FL_PARTIAL = 1;
  localparam int FL_CSUM    = 2;

  localparam logic [WORD_W-1:0] ACC_TIMEOUT_CODE = 32'h0000_0001;

  typedef enum logic [1:0] {
    AM_WPAIRS,
    AM_WBURST,
    AM_RBURST,
    AM_RLIST
  } acc_mode_e;

  function automatic logic cmd_known(input logic [WORD_W-1:0] c);
    return ((c[31:16] == OP_WRITE) || (c[31:16] == OP_READ)) &&
           ((c[15:0] == FORM_SINGLE) || (c[15:0] == FORM_BURST));
  endfunction

  function automatic acc_mode_e cmd_mode(input logic [WORD_W-1:0] c);
    acc_mode_e m;
    if (c[31:16] == OP_WRITE)
      m = (c[15:0] == FORM_BURST) ? AM_WBURST : AM_WPAIRS;
    else
      m = (c[15:0] == FORM_BURST) ? AM_RBURST : AM_RLIST;
    return m;
  endfunction

endpackage

// File: rtl/sc_frame_buf.sv
module sc_frame_buf #(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [31:0]           in_data,
  input  logic                  in_last,
  input  logic [2:0]            in_flags,
  output logic                  frame_rdy,
  input  logic                  release_i,
  output logic [3:0][31:0]      hdr_words,
  output logic [2:0]            hdr_cnt,
  output logic [CW-1:0]         data_cnt,
  output logic                  overflow,
  output logic [2:0]            flags_acc,
  input  logic [IW-1:0]         rd_idx,
  output logic [31:0]           rd_a,
  output logic [31:0]           rd_b
);

  logic [31:0] mem [DEPTH];
  logic        holding;
  logic        accept;
  logic        to_mem;

  assign in_ready  = !holding;
  assign frame_rdy = holding;
  assign accept    = in_valid && in_ready;
  assign to_mem    = accept && (hdr_cnt == 3'd4) && (data_cnt < CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holding   <= 1'b0;
      hdr_cnt   <= '0;
      data_cnt  <= '0;
      overflow  <= 1'b0;
      flags_acc <= '0;
      hdr_words <= '0;
    end else if (release_i) begin
      holding   <= 1'b0;
      hdr_cnt   <= '0;
      data_cnt  <= '0;
      overflow  <= 1'b0;
      flags_acc <= '0;
      hdr_words <= '0;
    end else if (accept) begin
      flags_acc <= flags_acc | in_flags;
      if (hdr_cnt < 3'd4) begin
        hdr_words[hdr_cnt[1:0]] <= in_data;
        hdr_cnt <= hdr_cnt + 3'd1;
      end else if (data_cnt < CW'(DEPTH)) begin
        data_cnt <= data_cnt + CW'(1);
      end else begin
        overflow <= 1'b1;
      end
      if (in_last) holding <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (to_mem) mem[data_cnt[IW-1:0]] <= in_data;
  end

  assign rd_a = mem[rd_idx];
  assign rd_b = mem[rd_idx + IW'(1)];

endmodule

// File: rtl/sc_bus_port.sv
module sc_bus_port #(
  parameter int TIMEOUT = 16,
  localparam int TW = $clog2(TIMEOUT + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        done,
  output logic [31:0] status,
  output logic [31:0] value,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata
);

  import sc_pkg::*;

  logic [TW-1:0] tcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      tcnt      <= '0;
      done      <= 1'b0;
      status    <= '0;
      value     <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        bus_req   <= 1'b1;
        bus_we    <= we;
        bus_addr  <= addr;
        bus_wdata <= wdata;
        tcnt      <= '0;
      end else if (bus_req) begin
        if (bus_ack) begin
          // acknowledge wins even in the last cycle of the window
          bus_req <= 1'b0;
          done    <= 1'b1;
          status  <= '0;
          value   <= bus_we ? bus_wdata : bus_rdata;
        end else if (tcnt == TW'(TIMEOUT - 1)) begin
          bus_req <= 1'b0;
          done    <= 1'b1;
          status  <= ACC_TIMEOUT_CODE;
          value   <= bus_we ? bus_wdata : '0;
        end else begin
          tcnt <= tcnt + TW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sc_exec.sv
module sc_exec #(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_rdy,
  output logic             release_o,
  input  logic [3:0][31:0] hdr_words,
  input  logic [2:0]       hdr_cnt,
  input  logic [CW-1:0]    data_cnt,
  input  logic             overflow,
  input  logic [2:0]       flags_acc,
  output logic [IW-1:0]    rd_idx,
  input  logic [31:0]      rd_a,
  input  logic [31:0]      rd_b,
  output logic             acc_start,
  output logic             acc_we,
  output logic [31:0]      acc_addr,
  output logic [31:0]      acc_wdata,
  input  logic             acc_done,
  input  logic [31:0]      acc_status,
  input  logic [31:0]      acc_value,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [31:0]      m_data,
  output logic             m_last
);

  import sc_pkg::*;

  typedef enum logic [3:0] {
    ST_IDLE, ST_EID, ST_EWORD, ST_HDR, ST_START,
    ST_BUS, ST_OSTAT, ST_OVAL, ST_REL
  } st_e;

  st_e          state;
  acc_mode_e    mode, mode_d;
  logic [31:0]  err_q, err_now, fr_bits, dec_bits;
  logic [1:0]   hidx;
  logic [IW-1:0] idx;
  logic [31:0]  baddr;
  logic [CW-1:0] acc_left, n_acc;
  logic         known;
  logic         take;

  assign known  = cmd_known(hdr_words[2]);
  assign mode_d = cmd_mode(hdr_words[2]);
  assign n_acc  = (mode_d == AM_WPAIRS) ? (data_cnt >> 1) : data_cnt;
  assign take   = m_valid && m_ready;
  assign rd_idx = idx;

  // rejection word, evaluated once the whole frame is held
  always_comb begin
    fr_bits = '0;
    fr_bits[EB_IDMSB]    = ~hdr_words[0][31];
    fr_bits[EB_SHORT]    = (hdr_cnt < 3'd4);
    fr_bits[EB_PARTIAL]  = flags_acc[FL_PARTIAL];
    fr_bits[EB_OVERFLOW] = overflow;
    fr_bits[EB_BADPORT]  = flags_acc[FL_PORT];
    dec_bits = '0;
    if (fr_bits == '0) begin
      dec_bits[EB_UNKNOWN] = !known;
      dec_bits[EB_BADFORM] = known && (mode_d == AM_WPAIRS) && data_cnt[0];
    end
    dec_bits[EB_CSUM] = flags_acc[FL_CSUM];
    err_now = fr_bits | dec_bits;
  end

  // operands of the current access
  always_comb begin
    acc_we    = 1'b0;
    acc_addr  = baddr;
    acc_wdata = '0;
    unique case (mode)
      AM_WPAIRS: begin acc_we = 1'b1; acc_addr = rd_a; acc_wdata = rd_b; end
      AM_WBURST: begin acc_we = 1'b1; acc_addr = baddr; acc_wdata = rd_a; end
      AM_RBURST: begin acc_addr = baddr; end
      AM_RLIST:  begin acc_addr = rd_a; end
      default:   begin acc_addr = baddr; end
    endcase
  end

  assign acc_start = (state == ST_START);
  assign release_o = (state == ST_REL);

  always_comb begin
    m_valid = 1'b0;
    m_data  = '0;
    m_last  = 1'b0;
    unique case (state)
      ST_EID: begin
        m_valid = 1'b1;
        m_data  = {1'b0, hdr_words[0][30:0]};
      end
      ST_EWORD: begin
        m_valid = 1'b1;
        m_data  = err_q;
        m_last  = 1'b1;
      end
      ST_HDR: begin
        m_valid = 1'b1;
        m_data  = (hidx == 2'd0) ? {1'b0, hdr_words[0][30:0]} : hdr_words[hidx];
        m_last  = (hidx == 2'd3) && (acc_left == '0);
      end
      ST_OSTAT: begin
        m_valid = 1'b1;
        m_data  = acc_status;
      end
      ST_OVAL: begin
        m_valid = 1'b1;
        m_data  = acc_value;
        m_last  = (acc_left == CW'(1));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mode     <= AM_WPAIRS;
      err_q    <= '0;
      hidx     <= '0;
      idx      <= '0;
      baddr    <= '0;
      acc_left <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (frame_rdy) begin
          err_q    <= err_now;
          hidx     <= '0;
          idx      <= '0;
          baddr    <= hdr_words[3];
          mode     <= mode_d;
          acc_left <= n_acc;
          state    <= (err_now != '0) ? ST_EID : ST_HDR;
        end
        ST_EID:   if (take) state <= ST_EWORD;
        ST_EWORD: if (take) state <= ST_REL;
        ST_HDR: if (take) begin
          if (hidx == 2'd3) state <= (acc_left == '0) ? ST_REL : ST_START;
          else hidx <= hidx + 2'd1;
        end
        ST_START: state <= ST_BUS;
        ST_BUS:   if (acc_done) state <= ST_OSTAT;
        ST_OSTAT: if (take) state <= ST_OVAL;
        ST_OVAL: if (take) begin
          if (acc_left == CW'(1)) begin
            state <= ST_REL;
          end else begin
            state <= ST_START;
            idx   <= idx + ((mode == AM_WPAIRS) ? IW'(2) : IW'(1));
            baddr <= baddr + 32'd1;
          end
          acc_left <= acc_left - CW'(1);
        end
        ST_REL:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sc_request_engine.sv
module sc_request_engine #(
  parameter int DEPTH   = 64,
  parameter int TIMEOUT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [31:0] s_data,
  input  logic        s_last,
  input  logic [2:0]  s_flags,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [31:0] m_data,
  output logic        m_last,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata
);

  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic             frame_rdy, release_w, overflow;
  logic [3:0][31:0] hdr_words;
  logic [2:0]       hdr_cnt, flags_acc;
  logic [CW-1:0]    data_cnt;
  logic [IW-1:0]    rd_idx;
  logic [31:0]      rd_a, rd_b;
  logic             acc_start, acc_we, acc_done;
  logic [31:0]      acc_addr, acc_wdata, acc_status, acc_value;

  sc_frame_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s_valid), .in_ready(s_ready), .in_data(s_data),
    .in_last(s_last), .in_flags(s_flags),
    .frame_rdy(frame_rdy), .release_i(release_w),
    .hdr_words(hdr_words), .hdr_cnt(hdr_cnt), .data_cnt(data_cnt),
    .overflow(overflow), .flags_acc(flags_acc),
    .rd_idx(rd_idx), .rd_a(rd_a), .rd_b(rd_b)
  );

  sc_exec #(.DEPTH(DEPTH)) u_exec (
    .clk(clk), .rst_n(rst_n),
    .frame_rdy(frame_rdy), .release_o(release_w),
    .hdr_words(hdr_words), .hdr_cnt(hdr_cnt), .data_cnt(data_cnt),
    .overflow(overflow), .flags_acc(flags_acc),
    .rd_idx(rd_idx), .rd_a(rd_a), .rd_b(rd_b),
    .acc_start(acc_start), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_done(acc_done),
    .acc_status(acc_status), .acc_value(acc_value),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last)
  );

  sc_bus_port #(.TIMEOUT(TIMEOUT)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .start(acc_start), .we(acc_we), .addr(acc_addr), .wdata(acc_wdata),
    .done(acc_done), .status(acc_status), .value(acc_value),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

endmodule

// File: rtl/sc_request_engine_chk.sv
module sc_request_engine_chk #(
  parameter int TIMEOUT = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        s_ready,
  input logic        m_valid,
  input logic        m_ready,
  input logic [31:0] m_data,
  input logic        m_last,
  input logic        bus_req,
  input logic        bus_we,
  input logic [31:0] bus_addr,
  input logic        bus_ack
);

  int   req_cycles;
  logic first_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_cycles <= 0;
      first_word <= 1'b1;
    end else begin
      req_cycles <= bus_req ? req_cycles + 1 : 0;
      if (m_valid && m_ready) first_word <= m_last;
    end
  end

  // R11: reply held steady under back-pressure
  p_hold_reply_r11: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_last));

  // R11: no new request words while a reply is in flight
  p_no_accept_in_reply_r11: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready);

  // R8: no register access while a frame is still arriving
  p_no_bus_in_recv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !bus_req);

  // R1: first reply word has bit 31 cleared
  p_reply_id_msb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && first_word |-> !m_data[31]);

  // R7: request never outlives the acknowledge window
  p_req_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> req_cycles < TIMEOUT);

  // R6: an acknowledge closes the access
  p_ack_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req);

  // R6: access operands steady while waiting
  p_req_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack && req_cycles < TIMEOUT - 1 |=>
      bus_req && $stable(bus_addr) && $stable(bus_we));

endmodule

bind sc_request_engine sc_request_engine_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
  .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_ack(bus_ack)
);

// File: tb/tb_sc_request_engine.sv
module tb_sc_request_engine;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int TIMEOUT    = 16;
  localparam int MAXW       = 200;

  logic        clk, rst_n;
  logic        s_valid, s_ready, s_last;
  logic [31:0] s_data;
  logic [2:0]  s_flags;
  logic        m_valid, m_ready, m_last;
  logic [31:0] m_data;
  logic        bus_req, bus_we, bus_ack;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;

  sc_request_engine #(.DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) dut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .s_flags(s_flags),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int stab_err = 0;
  int bus_starts = 0;

  logic [31:0] mem_act [256];
  logic [31:0] exp_mem [256];
  logic [31:0] fw [MAXW];
  int          fn;
  logic [2:0]  ff;
  logic [31:0] ex [MAXW];
  int          en;
  logic [31:0] got [MAXW];
  int          gn;

  // register model: 0xDE page never answers, 0xCF page answers in the last window cycle
  int   wcnt, lat;
  logic req_d;
  always @(posedge clk) begin
    bus_ack <= 1'b0;
    req_d   <= bus_req;
    if (bus_req && !req_d) bus_starts <= bus_starts + 1;
    if (bus_req && !bus_ack && bus_addr[15:8] != 8'hDE) begin
      if (wcnt >= ((bus_addr[15:8] == 8'hCF) ? TIMEOUT - 2 : lat)) begin
        bus_ack <= 1'b1;
        wcnt    <= 0;
        lat     <= $urandom % 4;
        if (bus_we) mem_act[bus_addr[7:0]] <= bus_wdata;
        else        bus_rdata <= mem_act[bus_addr[7:0]];
      end else begin
        wcnt <= wcnt + 1;
      end
    end else if (!bus_req) begin
      wcnt <= 0;
    end
  end

  task automatic chk(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", msg, act, expv);
    end
  endtask

  task automatic add_acc(input bit we, input logic [31:0] a, input logic [31:0] wd);
    if (a[15:8] == 8'hDE) begin
      ex[en] = 32'h1;
      ex[en+1] = we ? wd : 32'h0;
    end else begin
      ex[en] = 32'h0;
      if (we) begin exp_mem[a[7:0]] = wd; ex[en+1] = wd; end
      else ex[en+1] = exp_mem[a[7:0]];
    end
    en += 2;
  endtask

  task automatic build_exp();
    logic [31:0] e;
    logic [31:0] fr;
    int nd;
    bit known;
    e = 0;
    if (!fw[0][31]) e[26] = 1'b1;
    if (fn < 4) e[27] = 1'b1;
    if (ff[1]) e[28] = 1'b1;
    if (ff[0]) e[30] = 1'b1;
    nd = (fn > 4) ? fn - 4 : 0;
    if (nd > DEPTH) e[29] = 1'b1;
    fr = e;
    if (fr == 0) begin
      known = (fw[2] == 32'hAAAAFFFF) || (fw[2] == 32'hAAAABBBB) ||
              (fw[2] == 32'hBBBBBBBB) || (fw[2] == 32'hBBBBFFFF);
      if (!known) e[19] = 1'b1;
      else if (fw[2] == 32'hAAAAFFFF && (nd % 2) == 1) e[18] = 1'b1;
    end
    if (ff[2]) e[16] = 1'b1;
    ex[0] = {1'b0, fw[0][30:0]};
    if (e != 0) begin
      ex[1] = e;
      en = 2;
      return;
    end
    ex[1] = fw[1]; ex[2] = fw[2]; ex[3] = fw[3];
    en = 4;
    case (fw[2])
      32'hAAAAFFFF: for (int k = 0; k < nd / 2; k++) add_acc(1'b1, fw[4+2*k], fw[5+2*k]);
      32'hAAAABBBB: for (int k = 0; k < nd; k++) add_acc(1'b1, fw[3] + k, fw[4+k]);
      32'hBBBBBBBB: for (int k = 0; k < nd; k++) add_acc(1'b0, fw[3] + k, 32'h0);
      default:      for (int k = 0; k < nd; k++) add_acc(1'b0, fw[4+k], 32'h0);
    endcase
  endtask

  task automatic send_frame();
    int i = 0;
    while (i < fn) begin
      @(negedge clk);
      if ($urandom % 5 == 0) begin
        s_valid = 1'b0;
      end else begin
        s_valid = 1'b1;
        s_data  = fw[i];
        s_last  = (i == fn - 1);
        s_flags = (i == fn - 1) ? ff : 3'b000;
        if (s_ready) i++;
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    s_last  = 1'b0;
    s_flags = 3'b000;
  endtask

  task automatic get_reply();
    bit done = 0;
    bit hold = 0;
    logic [31:0] pd;
    logic pl;
    gn = 0;
    pd = 0;
    pl = 0;
    while (!done) begin
      @(negedge clk);
      if (hold && (m_data !== pd || m_last !== pl || m_valid !== 1'b1)) stab_err++;
      m_ready = ($urandom % 3 != 0);
      if (m_valid && m_ready) begin
        if (gn < MAXW) got[gn] = m_data;
        gn++;
        if (m_last) done = 1;
      end
      hold = m_valid && !m_ready;
      pd = m_data;
      pl = m_last;
    end
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  task automatic run_frame(input string tag);
    int bad = -1;
    build_exp();
    send_frame();
    get_reply();
    if (gn != en) begin
      chk(1'b0, {tag, " reply length"}, gn, en);
    end else begin
      for (int k = 0; k < en; k++) if (bad < 0 && got[k] !== ex[k]) bad = k;
      if (bad >= 0) chk(1'b0, $sformatf("%s word %0d", tag, bad), got[bad], ex[bad]);
      else chk(1'b1, tag, 0, 0);
    end
  endtask

  task automatic hdr(input logic [31:0] id, input logic [31:0] sub, input logic [31:0] cmd, input logic [31:0] arg);
    fw[0] = id; fw[1] = sub; fw[2] = cmd; fw[3] = arg;
    fn = 4;
    ff = 3'b000;
  endtask

  function automatic logic [31:0] rnd_addr();
    int r = $urandom % 10;
    logic [7:0] lo = 8'($urandom);
    if (r == 0) return {16'h0, 8'hDE, lo};
    if (r == 1) return {16'h0, 8'hCF, lo};
    return {24'h0, lo};
  endfunction

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: reply not completed actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int starts0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem_act[i] = (i * 32'h01030507) ^ 32'hA5A50000;
      exp_mem[i] = mem_act[i];
    end
    wcnt = 0; lat = 1; req_d = 0; bus_ack = 0; bus_rdata = 0;
    s_valid = 0; s_data = 0; s_last = 0; s_flags = 0; m_ready = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(s_ready === 1'b1, "R11 reset s_ready", s_ready, 1);
    chk(m_valid === 1'b0 && bus_req === 1'b0, "R11 reset m_valid/bus_req", {m_valid, bus_req}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R1 pair writes, argument ignored
    hdr(32'h8000_1234, 32'h0000_0007, 32'hAAAAFFFF, 32'hDEAD_BEEF);
    fw[4] = 32'h10; fw[5] = 32'h1111_1111; fw[6] = 32'h20; fw[7] = 32'h2222_2222; fn = 8;
    run_frame("R2 R1 write pairs");

    // R5 R6 list read back
    hdr(32'hF000_0001, 32'h1, 32'hBBBBFFFF, 32'h0);
    fw[4] = 32'h20; fw[5] = 32'h10; fw[6] = 32'h33; fn = 7;
    run_frame("R5 R6 read list");

    // R3 burst write
    hdr(32'h8000_0002, 32'h2, 32'hAAAABBBB, 32'h40);
    fw[4] = 32'hAAAA_0001; fw[5] = 32'hBBBB_0002; fw[6] = 32'hCCCC_0003; fn = 7;
    run_frame("R3 write burst");

    // R4 burst read, dummy words ignored
    hdr(32'h8000_0003, 32'h3, 32'hBBBBBBBB, 32'h3F);
    fw[4] = 32'hFFFF_FFFF; fw[5] = 32'h0; fw[6] = 32'h1234_5678; fw[7] = 32'h9; fn = 8;
    run_frame("R4 read burst");

    // R13 no payload
    hdr(32'h8000_0004, 32'h4, 32'hBBBBBBBB, 32'h10);
    run_frame("R13 empty payload");

    // R7 timeout on write and read, plus last-cycle acknowledge
    hdr(32'h8000_0005, 32'h5, 32'hAAAAFFFF, 32'h0);
    fw[4] = 32'hDE05; fw[5] = 32'h5555_AAAA; fw[6] = 32'hCF07; fw[7] = 32'h7777_0000; fn = 8;
    run_frame("R7 write timeout/late ack");
    hdr(32'h8000_0006, 32'h6, 32'hBBBBFFFF, 32'h0);
    fw[4] = 32'hDE06; fw[5] = 32'hCF07; fw[6] = 32'h10; fn = 7;
    run_frame("R7 read timeout/late ack");

    // R8 identifier MSB clear, no bus activity
    starts0 = bus_starts;
    hdr(32'h0000_0099, 32'h0, 32'hAAAAFFFF, 32'h0);
    fw[4] = 32'h50; fw[5] = 32'h1; fn = 6;
    run_frame("R8 R9 id msb clear");
    chk(bus_starts == starts0, "R8 no access on reject", bus_starts - starts0, 0);

    // R9 short frame and receive flags
    hdr(32'h8000_0010, 32'h0, 32'h0, 32'h0); fn = 2;
    run_frame("R9 short frame");
    hdr(32'h8000_0011, 32'h0, 32'hBBBBFFFF, 32'h0); ff = 3'b011;
    run_frame("R9 port+partial flags");

    // R10 decoder errors
    hdr(32'h8000_0012, 32'h0, 32'hAAAAFFFF, 32'h0);
    fw[4] = 32'h10; fw[5] = 32'h1; fw[6] = 32'h11; fn = 7;
    run_frame("R10 odd pairs");
    hdr(32'h8000_0013, 32'h0, 32'hAAAA1234, 32'h0);
    run_frame("R10 unknown command");
    hdr(32'h8000_0014, 32'h0, 32'hBBBBFFFF, 32'h0); ff = 3'b100;
    run_frame("R10 checksum flag");
    hdr(32'h0000_0015, 32'h0, 32'h1234_5678, 32'h0); ff = 3'b100;
    run_frame("R10 decoder suppressed");

    // R12 capacity boundary and overflow
    hdr(32'h8000_0020, 32'h0, 32'hAAAABBBB, 32'h80);
    for (int k = 0; k < DEPTH; k++) fw[4+k] = 32'hC000_0000 + k;
    fn = 4 + DEPTH;
    run_frame("R12 full payload");
    hdr(32'h8000_0021, 32'h0, 32'hAAAABBBB, 32'h90);
    for (int k = 0; k < DEPTH + 2; k++) fw[4+k] = 32'hE000_0000 + k;
    fn = 6 + DEPTH;
    starts0 = bus_starts;
    build_exp();
    send_frame();
    chk(s_ready === 1'b0, "R11 s_ready low after last word", s_ready, 0);
    get_reply();
    chk(gn == 2 && got[1] == ex[1], "R12 overflow error word", got[1], ex[1]);
    chk(bus_starts == starts0, "R12 no access on overflow", bus_starts - starts0, 0);

    // random mix
    for (int n = 0; n < 40; n++) begin
      int kind = $urandom % 4;
      int nd = $urandom % 9;
      fw[0] = ($urandom % 8 == 0) ? ($urandom & 32'h7FFF_FFFF) : (32'h8000_0000 | $urandom);
      fw[1] = $urandom;
      ff = 3'b000;
      case (kind)
        0: begin fw[2] = 32'hAAAAFFFF; fw[3] = $urandom; nd = nd & ~1;
             for (int k = 0; k < nd; k += 2) begin fw[4+k] = rnd_addr(); fw[5+k] = $urandom; end end
        1: begin fw[2] = 32'hAAAABBBB; fw[3] = {24'h0, 8'($urandom)};
             for (int k = 0; k < nd; k++) fw[4+k] = $urandom; end
        2: begin fw[2] = 32'hBBBBBBBB; fw[3] = {24'h0, 8'($urandom)};
             for (int k = 0; k < nd; k++) fw[4+k] = $urandom; end
        default: begin fw[2] = 32'hBBBBFFFF; fw[3] = $urandom;
             for (int k = 0; k < nd; k++) fw[4+k] = rnd_addr(); end
      endcase
      fn = 4 + nd;
      run_frame($sformatf("R1 R6 random frame %0d", n));
    end

    chk(stab_err == 0, "R11 reply stable under back-pressure", stab_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule